// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block sequences the instructions of a small macro processor. The macro program sits in an instruction memory outside the block. A start request supplies a word offset into that memory, the first macro parameter and the number of parameters the caller has supplied. The block then keeps a byte program counter and presents the fetch address. It decodes the operation class of each fetched word and reads two source registers from its internal register file. The current instruction goes out to an external ALU/bitfield datapath, which returns the value to be written back. The datapath also reports whether it used a macro parameter.

Control flow is the core of the block. A conditional branch tests one register against zero. When taken, it either runs exactly one delay-slot instruction before it redirects, or, with its annul bit set, redirects at once. An exit bit also carries a one-instruction slot before the block halts. An exit placed in a branch's delay slot therefore lets the branch target run as the final instruction. Illegal control flow, undefined operation classes and a parameter-count mismatch all end the run with an error.

Top module: `macro_seq`

Instruction fields: bits [2:0] are the operation class (0 to 5 datapath classes, 6 branch, 7 undefined). Bit 3 belongs to the datapath. Bit 4 selects the branch condition (0: register equals zero, 1: register not zero). Bit 5 is the annul bit and bit 7 is the exit bit. Bits [10:8] name the destination, [13:11] source A and [16:14] source B. Bits [31:14] hold a signed branch offset counted in words.

## Requirements
- R1: On a start request while idle, the block clears every register and its pending-branch and exit state, sets the program counter to 0, loads register 1 with the first parameter and sets the parameter index to 1. The context-clear output pulses in that same cycle.
- R2: The fetch address is the start offset plus the byte program counter divided by 4. With no branch in effect, the program counter advances by 4 per executed instruction.
- R3: A branch (class 6) tests the register named by bits [13:11]. With bit 4 at 0 it is taken when that register is zero; with bit 4 at 1 it is taken when the register is non-zero.
- R4: A taken branch with bit 5 clear executes exactly one following instruction, then continues at the branch's own address plus the sign-extended offset in bits [31:14] times 4.
- R5: A taken branch with bit 5 set skips the delay slot and fetches the target next.
- R6: An instruction with bit 7 set is followed by exactly one more instruction, after which busy falls and done pulses for one cycle.
- R7: An exit-flagged instruction in a branch delay slot makes the branch target the final instruction.
- R8: Register 0 always reads as zero; writes to it are dropped.
- R9: A branch in a delay slot or in the exit slot halts the run with the error output set.
- R10: Operation class 7 halts the run with the error output set and writes no register.
- R11: Each datapath-class instruction that reports a parameter use advances the parameter index. At the end of a run, error is set if the final index differs from the supplied parameter count.
- R12: Datapath-class instructions (0 to 5) write the returned result into the register named by bits [10:8]; branches write nothing.
- R13: The exit bit of a taken branch is ignored; the exit bit of a branch that is not taken is honoured.
- R14: A start request while busy is ignored and does not disturb the running macro.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken only when idle |
| start_offset | input | IMEM_AW | Word offset of the macro in instruction memory |
| first_param | input | DW | First macro parameter, loaded into register 1 |
| param_total | input | PCNT_W | Number of parameters supplied |
| busy | output | 1 | A macro is executing |
| done | output | 1 | One-cycle pulse after the run ends |
| error | output | 1 | Run ended on a fault or a parameter mismatch; held until the next start |
| ctx_clear | output | 1 | Pulse telling the datapath to clear method address and carry |
| imem_addr | output | IMEM_AW | Instruction memory word address |
| imem_rdata | input | 32 | Instruction word (combinational read) |
| exec_valid | output | 1 | An instruction is being executed this cycle |
| exec_word | output | 32 | The instruction being executed |
| src_a_val | output | DW | Source A register value |
| src_b_val | output | DW | Source B register value |
| param_idx | output | PCNT_W | Index of the next parameter to fetch |
| res_data | input | DW | Write-back value from the datapath |
| res_param_taken | input | 1 | Datapath used a parameter for this instruction |

## Verification
The bench builds the block with a 6-bit instruction address (a 64-word memory), eight 32-bit registers and an 8-bit parameter counter. With a memory this small, a randomly placed 20-word program with forward branches ends in the exit-padded tail within a few dozen cycles. Runs are therefore short enough to sweep many delay-slot, annul, exit-slot and branch-in-slot combinations. The same memory also lets each fetch address be compared against a model as a plain 6-bit index.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int RA_W   = 3;
  localparam int BOFF_W = 18;
  localparam int IW     = 32;

  typedef enum logic [2:0] {
    OPC_ALU    = 3'd0,
    OPC_ADDI   = 3'd1,
    OPC_BFINS  = 3'd2,
    OPC_EXSHI  = 3'd3,
    OPC_EXSHR  = 3'd4,
    OPC_LOAD   = 3'd5,
    OPC_BRANCH = 3'd6,
    OPC_UNDEF  = 3'd7
  } op_class_e;

  typedef struct packed {
    op_class_e           cls;
    logic                exit_f;
    logic                cond_nz;
    logic                annul;
    logic [RA_W-1:0]     dst;
    logic [RA_W-1:0]     src_a;
    logic [RA_W-1:0]     src_b;
    logic [BOFF_W-1:0]   boff;
  } instr_t;

  function automatic logic cond_holds(input logic want_nz, input logic reg_is_zero);
    return want_nz ? !reg_is_zero : reg_is_zero;
  endfunction

endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  logic [IW-1:0] word,
  output instr_t        ins,
  output logic          is_branch,
  output logic          bad_op
);

  logic unused_bits;

  always_comb begin
    ins.cls     = op_class_e'(word[2:0]);
    ins.cond_nz = word[4];
    ins.annul   = word[5];
    ins.exit_f  = word[7];
    ins.dst     = word[10:8];
    ins.src_a   = word[13:11];
    ins.src_b   = word[16:14];
    ins.boff    = word[31:14];
  end

  assign is_branch   = (ins.cls == OPC_BRANCH);
  assign bad_op      = (ins.cls == OPC_UNDEF);
  assign unused_bits = ^{word[6], word[3]};

endmodule

// File: rtl/mseq_regfile.sv
module mseq_regfile
  import mseq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [DW-1:0]   init_r1,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [RA_W-1:0] raddr_a,
  input  logic [RA_W-1:0] raddr_b,
  output logic [DW-1:0]   rdata_a,
  output logic [DW-1:0]   rdata_b
);

  logic [DW-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (clr) begin
          q <= (g == 1) ? init_r1 : '0;
        end else if (we && (waddr == RA_W'(g))) begin
          q <= wdata;
        end
      end
      assign regs[g] = q;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mseq_flow.sv
module mseq_flow
  import mseq_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              is_branch,
  input  logic              bad_op,
  input  logic              exit_f,
  input  logic              cond_nz,
  input  logic              annul,
  input  logic [BOFF_W-1:0] boff,
  input  logic              src_a_zero,
  input  logic              cnt_ok,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [PC_W-1:0]   pc,
  output logic              wr_allow
);

  logic            busy_q, done_q, err_q, dly_v_q, last_q;
  logic [PC_W-1:0] pc_q, dly_pc_q;

  logic            in_slot, slot_branch, fault, taken, take_annul, take_plain;
  logic            exit_req, finish, halt;
  logic [PC_W-1:0] tgt, nxt;

  function automatic logic [PC_W-1:0] branch_dest(input logic [PC_W-1:0] at,
                                                  input logic [BOFF_W-1:0] off);
    logic [PC_W-1:0] delta;
    delta = PC_W'($signed(off)) << 2;
    return at + delta;
  endfunction

  function automatic logic [PC_W-1:0] next_seq(input logic [PC_W-1:0] at);
    return at + PC_W'(4);
  endfunction

  always_comb begin
    in_slot     = dly_v_q | last_q;
    slot_branch = busy_q && is_branch && in_slot;
    fault       = busy_q && (slot_branch || bad_op);
    taken       = busy_q && is_branch && !in_slot && cond_holds(cond_nz, src_a_zero);
    take_annul  = taken && annul;
    take_plain  = taken && !annul;
    tgt         = branch_dest(pc_q, boff);
    exit_req    = busy_q && exit_f && !taken && !last_q && !fault;
    finish      = busy_q && last_q && !fault;
    halt        = fault || finish;
    wr_allow    = busy_q && !is_branch && !bad_op;
    if (take_annul)   nxt = tgt;
    else if (dly_v_q) nxt = dly_pc_q;
    else              nxt = next_seq(pc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      dly_v_q  <= 1'b0;
      last_q   <= 1'b0;
      pc_q     <= '0;
      dly_pc_q <= '0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      dly_v_q  <= 1'b0;
      last_q   <= 1'b0;
      pc_q     <= '0;
      dly_pc_q <= '0;
    end else if (busy_q) begin
      if (halt) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        err_q   <= fault | !cnt_ok;
        dly_v_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        pc_q     <= nxt;
        dly_v_q  <= take_plain;
        dly_pc_q <= tgt;
        last_q   <= exit_req;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign error = err_q;
  assign pc    = pc_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_q && pc_q == '0 && !dly_v_q && !last_q) else $error("start state"); // R1
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !taken && !dly_v_q && !halt |=> pc_q == $past(pc_q) + PC_W'(4)) else $error("pc step"); // R2
  AST_DELAY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    take_plain |=> busy_q && dly_v_q) else $error("delay slot"); // R4
  AST_DELAY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    dly_v_q && !halt |=> pc_q == $past(dly_pc_q)) else $error("redirect"); // R4
  AST_ANNUL_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    take_annul |=> busy_q && pc_q == $past(tgt)) else $error("annul"); // R5
  AST_EXIT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q && done_q) else $error("exit halt"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done pulse"); // R6
  AST_SLOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    slot_branch |=> err_q && done_q && !busy_q) else $error("slot branch"); // R9
  AST_UNDEF_OP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && bad_op |=> err_q && !busy_q) else $error("undef op"); // R10
  AST_PARAM_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    finish && !cnt_ok |=> err_q) else $error("param count"); // R11

endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import mseq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NREGS   = 8,
  parameter int IMEM_AW = 10,
  parameter int PCNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IMEM_AW-1:0] start_offset,
  input  logic [DW-1:0]      first_param,
  input  logic [PCNT_W-1:0]  param_total,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               ctx_clear,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [IW-1:0]      imem_rdata,
  output logic               exec_valid,
  output logic [IW-1:0]      exec_word,
  output logic [DW-1:0]      src_a_val,
  output logic [DW-1:0]      src_b_val,
  output logic [PCNT_W-1:0]  param_idx,
  input  logic [DW-1:0]      res_data,
  input  logic               res_param_taken
);

  localparam int PC_W = IMEM_AW + 2;

  instr_t               ins;
  logic                 is_branch, bad_op, launch, wr_allow, take_param, cnt_ok;
  logic [PC_W-1:0]      pc;
  logic [IMEM_AW-1:0]   offset_q;
  logic [PCNT_W-1:0]    pidx_q, pidx_next;

  assign launch    = start && !busy;
  assign ctx_clear = launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offset_q <= '0;
    else if (launch) offset_q <= start_offset;
  end

  assign imem_addr  = offset_q + pc[PC_W-1:2];
  assign exec_word  = imem_rdata;
  assign exec_valid = busy;

  mseq_decode u_decode (
    .word      (imem_rdata),
    .ins       (ins),
    .is_branch (is_branch),
    .bad_op    (bad_op)
  );

  mseq_regfile #(.DW(DW), .NREGS(NREGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .init_r1 (first_param),
    .we      (wr_allow),
    .waddr   (ins.dst),
    .wdata   (res_data),
    .raddr_a (ins.src_a),
    .raddr_b (ins.src_b),
    .rdata_a (src_a_val),
    .rdata_b (src_b_val)
  );

  assign take_param = wr_allow && res_param_taken;
  assign pidx_next  = pidx_q + PCNT_W'(take_param);
  assign cnt_ok     = (pidx_next == param_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pidx_q <= PCNT_W'(1);
    else if (launch)     pidx_q <= PCNT_W'(1);
    else if (take_param) pidx_q <= pidx_next;
  end

  assign param_idx = pidx_q;

  mseq_flow #(.PC_W(PC_W)) u_flow (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .is_branch  (is_branch),
    .bad_op     (bad_op),
    .exit_f     (ins.exit_f),
    .cond_nz    (ins.cond_nz),
    .annul      (ins.annul),
    .boff       (ins.boff),
    .src_a_zero (src_a_val == '0),
    .cnt_ok     (cnt_ok),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .pc         (pc),
    .wr_allow   (wr_allow)
  );

  AST_PIDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> pidx_q == PCNT_W'(1)) else $error("param index"); // R1
  AST_BUSY_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> offset_q == $past(offset_q)) else $error("relaunch"); // R14

endmodule

// File: tb/test_macro_seq.sv
module test_macro_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int PW = 8;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_offset = '0;
  logic [DW-1:0] first_param = '0;
  logic [PW-1:0] param_total = '0;
  logic          busy, done, error, ctx_clear, exec_valid, res_param_taken;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata, exec_word;
  logic [DW-1:0] src_a_val, src_b_val, res_data;
  logic [PW-1:0] param_idx;

  logic [31:0] mem [64];
  logic [31:0] prm [16];

  int n_chk = 0;
  int n_fail = 0;

  int          exp_n;
  bit          m_fault;
  int          m_pidx;
  logic [5:0]  exp_addr [256];
  logic [31:0] exp_a [256];
  logic [31:0] exp_b [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] dp(input logic [31:0] w, input logic [31:0] a,
                                     input logic [31:0] b, input logic [31:0] p);
    return w[3] ? p : (a + b + {17'd0, w[31:17]});
  endfunction

  assign imem_rdata      = mem[imem_addr];
  assign res_param_taken = exec_word[3];
  assign res_data        = dp(exec_word, src_a_val, src_b_val, prm[param_idx[3:0]]);

  macro_seq #(.DW(DW), .NREGS(8), .IMEM_AW(AW), .PCNT_W(PW)) i_macro_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
    .first_param(first_param), .param_total(param_total), .busy(busy), .done(done),
    .error(error), .ctx_clear(ctx_clear), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .exec_valid(exec_valid), .exec_word(exec_word), .src_a_val(src_a_val),
    .src_b_val(src_b_val), .param_idx(param_idx), .res_data(res_data),
    .res_param_taken(res_param_taken)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input int cls, input int dst, input int sa, input int sb,
                                     input bit ex, input bit nz, input bit an, input int off, input bit pt);
    logic [31:0] w;
    w = '0;
    w[2:0] = 3'(cls); w[3] = pt; w[4] = nz; w[5] = an; w[7] = ex;
    w[10:8] = 3'(dst); w[13:11] = 3'(sa);
    if (cls == 6) w[31:14] = 18'(off);
    else          w[16:14] = 3'(sb);
    return w;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0000_0080;
  endtask

  // Behavioural model of one run, written as a step list.
  task automatic model(input logic [5:0] off, input logic [31:0] p0);
    logic [31:0] r [8];
    logic [31:0] w, a, b;
    int pc, pend_pc;
    bit pend, final_slot, slot, tk;
    for (int i = 0; i < 8; i++) r[i] = '0;
    r[1] = p0; pc = 0; pend = 0; pend_pc = 0; final_slot = 0;
    m_pidx = 1; m_fault = 0; exp_n = 0;
    while (exp_n < 250) begin
      exp_addr[exp_n] = 6'(int'(off) + pc / 4);
      w = mem[exp_addr[exp_n]];
      a = r[w[13:11]]; b = r[w[16:14]];
      exp_a[exp_n] = a; exp_b[exp_n] = b;
      exp_n++;
      slot = pend || final_slot;
      if (w[2:0] == 3'd7 || (w[2:0] == 3'd6 && slot)) begin m_fault = 1; break; end
      if (w[2:0] == 3'd6) begin
        tk = w[4] ? (a != 0) : (a == 0);
        if (tk) begin
          if (w[5]) pc = (pc + 4 * int'($signed(w[31:14]))) & 255;
          else begin
            pend = 1; pend_pc = (pc + 4 * int'($signed(w[31:14]))) & 255;
            pc = (pc + 4) & 255;
          end
          continue;
        end
      end else begin
        if (w[10:8] != 0) r[w[10:8]] = dp(w, a, b, prm[m_pidx % 16]);
        if (w[3]) m_pidx++;
      end
      if (final_slot) break;
      if (pend) begin pc = pend_pc; pend = 0; end
      else pc = (pc + 4) & 255;
      final_slot = w[7];
    end
  endtask

  task automatic run_case(input string tag, input logic [5:0] off, input logic [31:0] p0,
                          input int total, input bit poke);
    bit exp_err;
    model(off, p0);
    exp_err = m_fault || (m_pidx != total);
    @(negedge clk);
    start = 1; start_offset = off; first_param = p0; param_total = PW'(total);
    #1 chk(ctx_clear === 1'b1, {tag, " R1 ctx_clear on start"}, 32'(ctx_clear), 1);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < exp_n; i++) begin
      chk(busy === 1'b1 && exec_valid === 1'b1, {tag, " R6 busy during run"}, 32'(busy), 1);
      chk(imem_addr === exp_addr[i], {tag, " R2 R4 R5 fetch address"}, 32'(imem_addr), 32'(exp_addr[i]));
      chk(src_a_val === exp_a[i], {tag, " R1 R8 R12 source A"}, src_a_val, exp_a[i]);
      chk(src_b_val === exp_b[i], {tag, " R1 R8 R12 source B"}, src_b_val, exp_b[i]);
      if (poke && i == 1) begin
        start = 1; start_offset = off + 6'd1;
        #1 chk(ctx_clear === 1'b0, {tag, " R14 start ignored while busy"}, 32'(ctx_clear), 0);
      end else start = 0;
      @(negedge clk);
      start = 0;
    end
    chk(busy === 1'b0 && done === 1'b1, {tag, " R6 halt and done pulse"}, {30'd0, busy, done}, 32'd1);
    chk(error === exp_err, {tag, " R9 R10 R11 error flag"}, 32'(error), 32'(exp_err));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R6 done one cycle"}, 32'(done), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) prm[i] = (i % 5 == 0) ? 32'd0 : $urandom;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 reset state idle", {29'd0, busy, done, error}, 0);
    chk(param_idx === PW'(1), "R1 reset parameter index", 32'(param_idx), 1);

    // R1 R2 R8 R12: write to r0 dropped, plain sequential run
    clear_mem();
    mem[5] = mk(0, 0, 1, 2, 0, 0, 0, 0, 1);
    mem[6] = mk(0, 3, 1, 0, 0, 0, 0, 0, 0);
    mem[7] = mk(0, 4, 0, 3, 1, 0, 0, 0, 0);
    mem[8] = mk(0, 2, 3, 4, 0, 0, 0, 0, 0);
    run_case("R8 seq", 6'd5, 32'hCAFE_0001, 2, 0);
    run_case("R11 mismatch", 6'd5, 32'h1234_5678, 3, 0);
    run_case("R14 poke", 6'd5, 32'h0BAD_F00D, 2, 1);

    // R4 R7: taken branch with delay slot holding exit
    clear_mem();
    mem[10] = mk(6, 0, 0, 0, 0, 0, 0, 3, 0);
    mem[11] = mk(0, 2, 1, 0, 1, 0, 0, 0, 0);
    mem[12] = mk(0, 5, 1, 1, 0, 0, 0, 0, 0);
    mem[13] = mk(0, 6, 2, 0, 0, 0, 0, 0, 0);
    run_case("R7 exit in slot", 6'd10, 32'h0000_0042, 1, 0);

    // R3 R5 R13: annulled nonzero branch, untaken zero branch with exit
    clear_mem();
    mem[20] = mk(6, 0, 1, 0, 1, 1, 1, 2, 0);
    mem[21] = mk(0, 7, 1, 1, 0, 0, 0, 0, 0);
    mem[22] = mk(6, 0, 1, 0, 1, 0, 0, 3, 0);
    mem[23] = mk(0, 2, 1, 0, 0, 0, 0, 0, 0);
    run_case("R5 R13 annul", 6'd20, 32'h0000_0009, 1, 0);
    run_case("R3 untaken nz", 6'd20, 32'h0000_0000, 1, 0);

    // R9: branch in delay slot
    clear_mem();
    mem[30] = mk(6, 0, 0, 0, 0, 0, 0, 2, 0);
    mem[31] = mk(6, 0, 0, 0, 0, 0, 1, 1, 0);
    run_case("R9 slot branch", 6'd30, 32'h1, 1, 0);

    // R10: undefined class
    clear_mem();
    mem[40] = mk(0, 3, 1, 1, 0, 0, 0, 0, 0);
    mem[41] = mk(7, 4, 1, 1, 0, 0, 0, 0, 0);
    run_case("R10 undef", 6'd40, 32'h5, 1, 0);

    // constrained random programs with forward branches
    for (int t = 0; t < 60; t++) begin
      logic [5:0] off;
      int sel, total;
      logic [31:0] w;
      clear_mem();
      off = 6'($urandom % 25);
      for (int k = 0; k < 20; k++) begin
        sel = $urandom % 32;
        w = $urandom;
        if (sel < 20)      w[2:0] = 3'(sel % 6);
        else if (sel < 30) w[2:0] = 3'd6;
        else               w[2:0] = (sel == 31) ? 3'd7 : 3'd0;
        w[3] = ($urandom % 4 == 0);
        w[6] = 1'b0;
        w[7] = ($urandom % 8 == 0);
        if (w[2:0] == 3'd6) begin
          w[31:14] = 18'($urandom % 4 + 1);
          if ($urandom % 3 == 0) w[13:11] = 3'd0;
        end
        mem[6'(int'(off) + k)] = w;
      end
      model(off, (t % 4 == 0) ? 32'd0 : $urandom);
      total = m_pidx + ((t % 5 == 0) ? 1 : 0);
      run_case("R2 R3 R4 R5 R6 R9 R11 random", off, (t % 4 == 0) ? 32'd0 : $urandom, total, 0);
    end

    summary();
    $finish;
  end
endmodule